// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple host port and a four-bank synchronous DRAM. It turns each host read or write request into one complete device access: it opens the row, issues one column command with auto-precharge, and waits until the bank is precharged again. It also handles the start-up programming of the device and schedules the periodic auto-refresh the memory needs. Every device timing rule is enforced by counting clocks. All timing values, the CAS latency and the address field widths are parameters.

The host side is valid/ready. The host holds `req_valid` with a stable `req_write`, `req_addr` and `req_wdata` until it sees `req_ready` high at a rising edge. Only that edge accepts the request. The block drops `req_ready` while it is initialising, while it is busy with an access or a refresh, and whenever a refresh is due. This is the only back-pressure. Each accepted request produces exactly one `resp_valid` pulse, and responses come back in request order. `resp_valid` cannot be stalled, so the host must always be able to take a response. Each access carries one data word, and the mode register is programmed for a burst length of one.

The memory side drives the active-low command strobes, the bank and row/column address lines, and the write data with its output enable. It samples `mem_dq_in` for read data.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: Commands are encoded on {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode set 0000. Every clock that carries no command shows the no-op code.
- R2: After reset the block waits T_INIT clocks. It then issues a precharge with mem_addr[10]=1 (all banks), an auto refresh, a second auto refresh and a mode set, in that order. `req_ready` stays low until T_MRD clocks after the mode set.
- R3: The mode set drives mem_ba=0 and mem_addr = CAS_LAT<<4, which selects burst length 1 and sequential order. No other command follows it within T_MRD clocks.
- R4: A read or write is issued exactly T_RCD clocks after its activate. It carries mem_addr[10]=1 (auto-precharge), the column on mem_addr[COL_W-1:0] and the same bank as the activate.
- R5: Two activates, or an activate and the next refresh, are at least T_RC clocks and at least T_RAS+T_RP clocks apart.
- R6: Write data is driven on mem_dq_out, with mem_dq_oe high, in the same clock as the write command and in no other clock. The next activate or refresh comes at least T_DAL clocks after a write.
- R7: For a read command issued at edge k, mem_dq_in is captured at edge k+CAS_LAT+1. It appears on resp_rdata with resp_valid high from that edge. A write's resp_valid is high from the edge that issues the write.
- R8: After any auto refresh, the next command comes no earlier than T_RFC clocks later.
- R9: A due refresh is served before any pending host request. req_ready is low while a refresh is owed, so a host that requests without pause cannot starve refresh.
- R10: After initialisation, one auto refresh is owed every REF_INTERVAL clocks (64 ms / 8192 at the default clock). Consecutive refreshes are never more than one interval plus one access apart.
- R11: A request is accepted only at an edge where req_valid and req_ready are both high. The activate goes out on that edge with bank = req_addr[24:23] and row = req_addr[22:10]. The column is req_addr[9:0].
- R12: Each accepted request yields exactly one resp_valid pulse, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | {bank, row, column} |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_rdata | output | 8 | Read data, valid with resp_valid on reads |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | 13 | Row / column / opcode address |
| mem_dq_out | output | 8 | Write data to the device |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Read data from the device |

## Verification
The assertions assume that the host follows the valid/ready rule and holds its request fields stable while it waits. They also assume that the device returns read data exactly CAS_LAT clocks after it samples a read. No assertion constrains the host's timing beyond that. The bench host always holds its fields until acceptance. Its device model returns read data on the clock the latency dictates, from whatever was last written at the decoded bank, row and column. Random traffic is drawn from a small address set so that reads often hit earlier writes, and an unbroken request stream tests the refresh priority.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_IPRE,
    ST_IREF1,
    ST_IREF2,
    ST_IMRS,
    ST_IDLE,
    ST_RCD,
    ST_POST,
    ST_RFC
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_delay_cnt.sv
module sdram_delay_cnt #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_req.sv
module sdram_refresh_req #(
  parameter int INTERVAL = 781,
  parameter int PEND_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pending
);
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

  logic [IW-1:0]     tick_cnt;
  logic [PEND_W-1:0] owed;
  logic              tick;

  assign tick = en && (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     tick_cnt <= '0;
    else if (!en)   tick_cnt <= '0;
    else if (tick)  tick_cnt <= '0;
    else            tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else begin
      case ({tick, ack && (owed != '0)})
        2'b10:   owed <= (owed == '1) ? owed : owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign pending = (owed != '0);
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DW      = 8,
  parameter int CAS_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [CAS_LAT:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= issue;
  end

  for (genvar i = 1; i <= CAS_LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[i] <= 1'b0;
      else        pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= pipe[CAS_LAT];
      if (pipe[CAS_LAT]) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int DW           = 8,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int CAS_LAT      = 2,
  parameter int T_INIT       = 20000,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 5,
  parameter int T_RC         = 7,
  parameter int T_MRD        = 2,
  parameter int T_DAL        = 5,
  parameter int T_RFC        = 7,
  parameter int REF_INTERVAL = 781
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]                 req_wdata,
  output logic                          resp_valid,
  output logic [DW-1:0]                 resp_rdata,
  output logic                          mem_cs_n,
  output logic                          mem_ras_n,
  output logic                          mem_cas_n,
  output logic                          mem_we_n,
  output logic [BANK_W-1:0]             mem_ba,
  output logic [ROW_W-1:0]              mem_addr,
  output logic [DW-1:0]                 mem_dq_out,
  output logic                          mem_dq_oe,
  input  logic [DW-1:0]                 mem_dq_in
);
  localparam int AW      = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT  = 10;
  localparam int POST_WR = max3(T_DAL, T_RC - T_RCD, T_RAS + T_RP - T_RCD);
  localparam int POST_RD = max3(CAS_LAT + 2, T_RC - T_RCD, T_RAS + T_RP - T_RCD);
  localparam int CNT_MAX = max3(T_INIT, max3(POST_WR, POST_RD, T_RFC),
                                max3(T_RP, T_MRD, T_RCD));
  localparam int CW      = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RFC = CW'(T_RFC - 1);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 1);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_PWR = CW'(POST_WR - 1);
  localparam logic [CW-1:0] L_PRD = CW'(POST_RD - 1);

  seq_state_e        state, nxt_state;
  sdram_cmd_e        cmd_q, cmd_n;
  logic [BANK_W-1:0] ba_n;
  logic [ROW_W-1:0]  addr_n;
  logic              ld;
  logic [CW-1:0]     ld_val;
  logic              cnt_zero;
  logic              ref_pending, ref_ack;
  logic              init_done;
  logic              issue_rd, issue_wr;
  logic              accept;
  logic [COL_W-1:0]  lat_col;
  logic              lat_write;
  logic [DW-1:0]     lat_wdata;
  logic              wr_done_q;
  logic              rd_valid;
  logic [DW-1:0]     rd_data;
  logic [ROW_W-1:0]  col_word, mode_word, all_word;

  always_comb begin
    col_word            = '0;
    col_word[COL_W-1:0] = lat_col;
    col_word[AP_BIT]    = 1'b1;
    mode_word           = '0;
    mode_word[6:4]      = 3'(CAS_LAT);
    all_word            = '0;
    all_word[AP_BIT]    = 1'b1;
  end

  sdram_delay_cnt #(.W(CW), .RST_VAL(T_INIT - 1)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(cnt_zero)
  );

  sdram_refresh_req #(.INTERVAL(REF_INTERVAL), .PEND_W(4)) u_refresh (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdram_rd_capture #(.DW(DW), .CAS_LAT(CAS_LAT)) u_capture (
    .clk(clk), .rst_n(rst_n), .issue(issue_rd), .dq_in(mem_dq_in),
    .rdata(rd_data), .rvalid(rd_valid)
  );

  assign init_done = (state != ST_PWR) && (state != ST_IPRE) && (state != ST_IREF1)
                   && (state != ST_IREF2) && (state != ST_IMRS);
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_state = state;
    cmd_n     = CMD_NOP;
    ba_n      = '0;
    addr_n    = '0;
    ld        = 1'b0;
    ld_val    = '0;
    issue_rd  = 1'b0;
    issue_wr  = 1'b0;
    ref_ack   = 1'b0;
    case (state)
      ST_PWR: if (cnt_zero) begin
        cmd_n = CMD_PRE; addr_n = all_word;
        ld = 1'b1; ld_val = L_RP; nxt_state = ST_IPRE;
      end
      ST_IPRE: if (cnt_zero) begin
        cmd_n = CMD_REF; ld = 1'b1; ld_val = L_RFC; nxt_state = ST_IREF1;
      end
      ST_IREF1: if (cnt_zero) begin
        cmd_n = CMD_REF; ld = 1'b1; ld_val = L_RFC; nxt_state = ST_IREF2;
      end
      ST_IREF2: if (cnt_zero) begin
        cmd_n = CMD_MRS; addr_n = mode_word;
        ld = 1'b1; ld_val = L_MRD; nxt_state = ST_IMRS;
      end
      ST_IMRS: if (cnt_zero) nxt_state = ST_IDLE;
      ST_IDLE: begin
        if (ref_pending) begin
          cmd_n = CMD_REF; ref_ack = 1'b1;
          ld = 1'b1; ld_val = L_RFC; nxt_state = ST_RFC;
        end else if (req_valid) begin
          cmd_n  = CMD_ACT;
          ba_n   = req_addr[AW-1 -: BANK_W];
          addr_n = req_addr[COL_W +: ROW_W];
          ld = 1'b1; ld_val = L_RCD; nxt_state = ST_RCD;
        end
      end
      ST_RCD: if (cnt_zero) begin
        cmd_n    = lat_write ? CMD_WR : CMD_RD;
        ba_n     = mem_ba;
        addr_n   = col_word;
        issue_wr = lat_write;
        issue_rd = !lat_write;
        ld = 1'b1; ld_val = lat_write ? L_PWR : L_PRD; nxt_state = ST_POST;
      end
      ST_POST: if (cnt_zero) nxt_state = ST_IDLE;
      ST_RFC:  if (cnt_zero) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_PWR;
      cmd_q      <= CMD_NOP;
      mem_ba     <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      wr_done_q  <= 1'b0;
      lat_col    <= '0;
      lat_write  <= 1'b0;
      lat_wdata  <= '0;
    end else begin
      state     <= nxt_state;
      cmd_q     <= cmd_n;
      mem_dq_oe <= issue_wr;
      wr_done_q <= issue_wr;
      if (cmd_n != CMD_NOP) begin
        mem_ba   <= ba_n;
        mem_addr <= addr_n;
      end
      if (issue_wr) mem_dq_out <= lat_wdata;
      if (accept && !ref_pending) begin
        lat_col   <= req_addr[COL_W-1:0];
        lat_write <= req_write;
        lat_wdata <= req_wdata;
      end
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign resp_valid = wr_done_q | rd_valid;
  assign resp_rdata = rd_data;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int MA_W  = 13,
  parameter int T_RCD = 2,
  parameter int T_RC  = 7,
  parameter int T_MRD = 2,
  parameter int T_RFC = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_cs_n,
  input logic            mem_ras_n,
  input logic            mem_cas_n,
  input logic            mem_we_n,
  input logic [MA_W-1:0] mem_addr,
  input logic            mem_dq_oe,
  input logic            req_valid,
  input logic            req_ready
);
  logic [3:0]  cmd;
  logic [15:0] since_act, since_ref, since_mrs;
  logic        is_col, is_cmd;

  assign cmd    = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  assign is_col = (cmd == 4'b0101) || (cmd == 4'b0100);
  assign is_cmd = (cmd != 4'b0111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 16'hFFFF;
      since_ref <= 16'hFFFF;
      since_mrs <= 16'hFFFF;
    end else begin
      since_act <= (cmd == 4'b0011) ? 16'd1 : ((since_act == 16'hFFFF) ? since_act : since_act + 16'd1);
      since_ref <= (cmd == 4'b0001) ? 16'd1 : ((since_ref == 16'hFFFF) ? since_ref : since_ref + 16'd1);
      since_mrs <= (cmd == 4'b0000) ? 16'd1 : ((since_mrs == 16'hFFFF) ? since_mrs : since_mrs + 16'd1);
    end
  end

  // R4: column command exactly T_RCD after its activate
  a_r4_rcd_exact: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act == 16'(T_RCD)));

  // R4: column commands always request auto-precharge
  a_r4_auto_pre: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> mem_addr[10]);

  // R5: row cycle between activates / activate and refresh
  a_r5_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 4'b0011) || (cmd == 4'b0001)) |-> (since_act >= 16'(T_RC)));

  // R3: quiet window after mode set
  a_r3_mrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_mrs >= 16'(T_MRD)));

  // R8: refresh cycle time respected
  a_r8_rfc_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_ref >= 16'(T_RFC)));

  // R6: data drive only with a write command
  a_r6_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (cmd == 4'b0100));

  // R11: an accepted request opens its row on the next edge
  a_r11_accept_act: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == 4'b0011));
endmodule

bind sdram_seq_ctrl sdram_seq_chk #(
  .MA_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_MRD(T_MRD), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe),
  .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/tb_sdram_seq_ctrl.sv
module tb_sdram_seq_ctrl;
  localparam int CL = 3, TI = 30, RI = 120;
  localparam int T_RCD = 2, T_RP = 2, T_RAS = 5, T_RC = 7, T_MRD = 2, T_DAL = 5, T_RFC = 7;
  localparam int SLACK = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, resp_valid, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [7:0] resp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = '0;
  logic [1:0] mem_ba;
  logic [12:0] mem_addr;

  sdram_seq_ctrl #(.CAS_LAT(CL), .T_INIT(TI), .REF_INTERVAL(RI)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] fill(input logic [24:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // host request bookkeeping
  logic [24:0] h_addr[$];
  logic        h_wr[$];
  logic [7:0]  h_data[$];
  int accepted = 0, responses = 0;
  int act_due = -1;
  logic [24:0] act_addr;

  // completion expectations
  int          c_due[$];
  logic        c_rd[$];
  logic [7:0]  c_data[$];

  logic [7:0] exp_mem[int];
  logic [7:0] dev_mem[int];
  logic [12:0] open_row[4];

  int last_act = -1000, last_ref = -1000, last_mrs = -1000, last_wr = -1000, last_pre = -1000;
  int init_idx = 0, ready_seen = 0, init_end = 0, post_refs = 0, prev_ref = -1;
  int dev_due = -1;
  logic [7:0] dev_val;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    if (rst_n) begin
      // R1: only defined codes appear
      if (!(c inside {4'b0111, 4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0001, 4'b0000}))
        chk(0, "R1 code", c, 7);
      if (!ready_seen) begin
        if (req_ready) begin
          ready_seen = 1; init_end = cyc;
          chk(init_idx == 4, "R2 init complete before ready", init_idx, 4);
          chk(cyc - last_mrs >= T_MRD, "R3 ready after mode gap", cyc - last_mrs, T_MRD);
        end else if (c != 4'b0111) begin
          case (init_idx)
            0: begin chk(c == 4'b0010 && mem_addr[10], "R2 first precharge all", c, 2);
                      chk(cyc >= TI, "R2 power-up wait", cyc, TI); end
            1: chk(c == 4'b0001 && cyc - last_pre >= T_RP, "R2 first refresh", c, 1);
            2: chk(c == 4'b0001 && cyc - last_ref >= T_RFC, "R2 second refresh", c, 1);
            3: begin chk(c == 4'b0000, "R2 mode set", c, 0);
                      chk(mem_addr == 13'(CL << 4) && mem_ba == 2'd0, "R3 mode word", mem_addr, CL << 4); end
            default: chk(0, "R2 extra init command", c, 7);
          endcase
          init_idx++;
        end
      end
      if (c != 4'b0111) begin
        chk(cyc - last_mrs >= T_MRD, "R3 mode gap", cyc - last_mrs, T_MRD);
        chk(cyc - last_ref >= T_RFC, "R8 refresh gap", cyc - last_ref, T_RFC);
      end
      if (act_due == cyc) begin
        chk(c == 4'b0011, "R11 activate on accept", c, 3);
        chk(mem_ba == act_addr[24:23] && mem_addr == act_addr[22:10], "R11 bank/row", mem_addr, act_addr[22:10]);
        act_due = -1;
      end
      case (c)
        4'b0011: begin
          chk(cyc - last_act >= T_RC && cyc - last_act >= T_RAS + T_RP, "R5 act gap", cyc - last_act, T_RC);
          chk(cyc - last_wr >= T_DAL, "R6 write to act", cyc - last_wr, T_DAL);
          open_row[mem_ba] = mem_addr; last_act = cyc;
        end
        4'b0001: begin
          chk(cyc - last_act >= T_RC, "R5 act to refresh", cyc - last_act, T_RC);
          chk(cyc - last_wr >= T_DAL, "R6 write to refresh", cyc - last_wr, T_DAL);
          if (ready_seen) begin
            post_refs++;
            if (prev_ref >= 0) chk(cyc - prev_ref <= RI + SLACK, "R9 R10 refresh spacing", cyc - prev_ref, RI);
            prev_ref = cyc;
          end
          last_ref = cyc;
        end
        4'b0010: last_pre = cyc;
        4'b0000: last_mrs = cyc;
        4'b0101, 4'b0100: begin
          logic [24:0] ha, da;
          logic hw; logic [7:0] hd;
          chk(cyc - last_act == T_RCD, "R4 rcd", cyc - last_act, T_RCD);
          chk(mem_addr[10] == 1'b1, "R4 auto-precharge", mem_addr[10], 1);
          if (h_addr.size() == 0) chk(0, "R11 column without request", 0, 1);
          else begin
            ha = h_addr.pop_front(); hw = h_wr.pop_front(); hd = h_data.pop_front();
            da = {mem_ba, open_row[mem_ba], mem_addr[9:0]};
            chk(da == ha, "R4 R11 decoded address", da, ha);
            chk(hw == (c == 4'b0100), "R11 direction", c, hw ? 4 : 5);
            if (c == 4'b0100) begin
              chk(mem_dq_oe && mem_dq_out == hd, "R6 write data", mem_dq_out, hd);
              exp_mem[int'(ha)] = hd; dev_mem[int'(da)] = mem_dq_out;
              last_wr = cyc;
              c_due.push_back(cyc); c_rd.push_back(1'b0); c_data.push_back(8'h00);
            end else begin
              c_due.push_back(cyc + CL + 1); c_rd.push_back(1'b1);
              c_data.push_back(exp_mem.exists(int'(ha)) ? exp_mem[int'(ha)] : fill(ha));
              dev_due = cyc + CL;
              dev_val = dev_mem.exists(int'(da)) ? dev_mem[int'(da)] : fill(da);
            end
          end
        end
        default: ;
      endcase
      if (mem_dq_oe && c != 4'b0100) chk(0, "R6 stray drive", 1, 0);
      if (dev_due == cyc) mem_dq_in = dev_val;
      // completions
      if (resp_valid) begin
        responses++;
        if (c_due.size() == 0) chk(0, "R12 unexpected response", 1, 0);
        else begin
          chk(c_due[0] == cyc, "R7 R12 response timing", cyc, c_due[0]);
          if (c_rd[0]) chk(resp_rdata == c_data[0], "R7 read data", resp_rdata, c_data[0]);
          void'(c_due.pop_front()); void'(c_rd.pop_front()); void'(c_data.pop_front());
        end
      end else if (c_due.size() != 0 && c_due[0] <= cyc) begin
        chk(0, "R12 missing response", cyc, c_due[0]);
        void'(c_due.pop_front()); void'(c_rd.pop_front()); void'(c_data.pop_front());
      end
    end
  end

  // call at a negedge; returns at a negedge with valid dropped
  task automatic send(input bit wr, input logic [24:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    accepted++;
    h_addr.push_back(a); h_wr.push_back(wr); h_data.push_back(d);
    act_due = cyc + 1; act_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [24:0] rnd_addr();
    logic [24:0] a;
    a[24:23] = 2'($urandom());
    a[22:10] = 13'($urandom_range(0, 3)) * 13'd1111;
    a[9:0]   = 10'($urandom_range(0, 7)) * 10'd73;
    return a;
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready == 1'b0 && resp_valid == 1'b0, "R2 reset ready low", req_ready, 0);
    chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "R1 reset no-op", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    while (!ready_seen) @(negedge clk);
    // directed corners: far corner address, unwritten read, write then read
    send(1'b1, {2'b11, 13'h1FFF, 10'h3FF}, 8'h3C);
    send(1'b0, {2'b11, 13'h1FFF, 10'h3FF}, 8'h00);
    send(1'b0, {2'b00, 13'h0000, 10'h000}, 8'h00);
    send(1'b1, {2'b01, 13'h0ABC, 10'h155}, 8'hC3);
    send(1'b1, {2'b01, 13'h0ABC, 10'h155}, 8'h5A);
    send(1'b0, {2'b01, 13'h0ABC, 10'h155}, 8'h00);
    repeat (20) @(negedge clk);
    // random mix
    for (int i = 0; i < 300; i++) begin
      send($urandom_range(0, 1) == 1, rnd_addr(), 8'($urandom()));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    // unbroken stream: refresh must still win
    for (int i = 0; i < 200; i++) send($urandom_range(0, 1) == 1, rnd_addr(), 8'($urandom()));
    repeat (60) @(negedge clk);
    chk(c_due.size() == 0 && h_addr.size() == 0, "R12 all drained", c_due.size(), 0);
    chk(responses == accepted, "R12 response count", responses, accepted);
    begin
      int span, expr;
      span = cyc - init_end; expr = span / RI;
      chk(post_refs >= expr - 1 && post_refs <= expr + 1, "R10 refresh count", post_refs, expr);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule